// File: doc/BRIEF.md
# Syllable Fetch and Interrupt-Injection Sequencer

This block is the instruction-stream front end of a processor whose program words carry several fixed-width syllables. It keeps the current program word, a syllable index and a word address. Each time the execution logic signals that a syllable has finished, the block places the next syllable in its syllable register. Syllables are taken from the most significant end of the word first. When the last syllable of a word is taken, the block advances the word address and fetches the next word from memory. While that fetch is outstanding, the syllable register is marked not valid.

At a syllable boundary the block can also take an interrupt. If an interrupt is pending and the processor is in normal (non-control) state, a fixed store-for-interrupt syllable is forced into the syllable register instead. The index and the address stay where they were, so the interrupted stream can resume. A hardware-induced bit in the miscellaneous flag register records the substitution.

At every syllable boundary the block also clears the flag register and issues clear strobes for the neighbouring serial and character-mode registers. It presents a two-bit primary class decode of the current syllable to the execution logic.

Top module: `syl_fetch_seq`

## Requirements
- R1: After reset the block requests a fetch at word address 0: `mem_req`=1, `mem_addr`=0, `t_valid`=0, `syl_idx`=0 and `q_flags`=0.
- R2: When the first fetch after reset is acknowledged, the cycle after the acknowledge shows `t_syl` = bits 47..36 of the returned word, `syl_idx`=1 and `t_valid`=1.
- R3: A syllable end is `syl_done` high while `t_valid`=1. At a syllable end with no injection and `syl_idx` k below 3, the next cycle shows `t_syl` = word bits (47−12k)..(36−12k) and `syl_idx` = k+1.
- R4: At a syllable end with no injection and `syl_idx`=3, the next cycle shows `t_syl` = word bits 11..0, `syl_idx`=0, `mem_addr` incremented by 1 and `mem_req`=1. `t_valid` stays 0 for as long as `mem_req` is high.
- R5: The cycle after `mem_ack` is high with a fetch outstanding, `t_valid`=1 and `mem_req`=0, the address is unchanged, and `mem_data` becomes the word that later syllables are taken from.
- R6: A syllable end with `int_pending`=1 and `normal_state`=1 is an injection. The next cycle shows `t_syl`=0x609, with `syl_idx` and `mem_addr` unchanged and `q_flags`=0x040: bit 6, the hardware-induced bit, is set and bit 8, the relative-addressing adder enable, is cleared.
- R7: A syllable end with `int_pending`=1 and `normal_state`=0 advances normally, as in R3 and R4.
- R8: A syllable end with no injection clears `q_flags` to 0. `clr_serial` is high, combinationally, exactly during a syllable end.
- R9: `clr_cm` is high, combinationally, exactly during a syllable end taken with `char_mode`=1.
- R10: `syl_class` decodes `t_syl[1:0]` as follows: 0 is literal (code 0), 1 is any other operator (code 1), 2 is operand call (code 2) and 3 is descriptor call (code 3).
- R11: `syl_done` is ignored while `t_valid`=0: `t_syl`, `syl_idx` and `mem_addr` do not change.
- R12: In a cycle with no syllable end, the bits of `q_set` are ORed into `q_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| syl_done | input | 1 | Execution of the current syllable is complete |
| int_pending | input | 1 | An interrupt is pending |
| normal_state | input | 1 | Processor is in normal (non-control) state |
| char_mode | input | 1 | Processor is in character mode |
| q_set | input | 9 | Flag bits set by execution logic |
| mem_ack | input | 1 | Memory returns the requested word |
| mem_data | input | 48 | Returned program word |
| mem_req | output | 1 | Program-word fetch outstanding |
| mem_addr | output | 15 | Word address (current program word address) |
| t_syl | output | 12 | Current syllable |
| t_valid | output | 1 | Current syllable is valid |
| syl_class | output | 2 | Primary class of current syllable |
| syl_idx | output | 2 | Index of the next syllable to take |
| q_flags | output | 9 | Miscellaneous flag register |
| clr_serial | output | 1 | Clear strobe for the serial character registers |
| clr_cm | output | 1 | Clear strobe for the character-mode registers |

## Verification
The bench builds the block with its default parameters: four 12-bit syllables per 48-bit word, a 15-bit address and a 9-bit flag register. With these values it walks 24 consecutive program words and checks every syllable slot of each. The walk interleaves injections and ignored interrupts with patterns that differ from one syllable boundary to the next. Memory latencies from zero to three wait cycles bring the not-valid window and the ignored `syl_done` within reach. Each word's content is derived arithmetically from its address, so every class code and every syllable position is exercised.

// File: rtl/sylseq_pkg.sv
package sylseq_pkg;

  typedef enum logic [1:0] {
    SC_LITERAL    = 2'd0,
    SC_OTHER      = 2'd1,
    SC_OPERAND    = 2'd2,
    SC_DESCRIPTOR = 2'd3
  } syl_class_e;

  function automatic syl_class_e class_of(input logic [1:0] low);
    syl_class_e c;
    case (low)
      2'd0:    c = SC_LITERAL;
      2'd2:    c = SC_OPERAND;
      2'd3:    c = SC_DESCRIPTOR;
      default: c = SC_OTHER;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/syl_select.sv
module syl_select #(
  parameter int SYL_W = 12,
  parameter int SYL_N = 4,
  localparam int IDX_W = $clog2(SYL_N),
  localparam int WORD_W = SYL_W * SYL_N
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  output logic [SYL_W-1:0]  syl
);
  // slot g is taken g-th, counting from the most significant end
  logic [SYL_W-1:0] slot [SYL_N];

  for (genvar g = 0; g < SYL_N; g++) begin : g_slot
    assign slot[g] = word[WORD_W-1-g*SYL_W -: SYL_W];
  end

  assign syl = slot[idx];
endmodule

// File: rtl/syl_class_dec.sv
module syl_class_dec
  import sylseq_pkg::*;
(
  input  logic [1:0]  low_bits,
  output syl_class_e  cls
);
  assign cls = class_of(low_bits);
endmodule

// File: rtl/q_flag_unit.sv
module q_flag_unit #(
  parameter int Q_W = 9,
  parameter int HW_BIT = 6,
  parameter int ADDER_BIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           syl_end,
  input  logic           inject,
  input  logic [Q_W-1:0] q_set,
  output logic [Q_W-1:0] q_out
);
  localparam logic [Q_W-1:0] INJ_VAL = Q_W'(1) << HW_BIT;

  logic [Q_W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)       q_r <= '0;
    else if (syl_end) q_r <= inject ? INJ_VAL : '0;
    else              q_r <= q_r | q_set;
  end

  assign q_out = q_r;

  assert_q_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (syl_end && !inject) |=> (q_out == '0));

  assert_q_inject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (syl_end && inject) |=> (q_out[HW_BIT] && !q_out[ADDER_BIT]));

  assert_q_accum_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!syl_end) |=> ((q_out & $past(q_out)) == $past(q_out)));
endmodule

// File: rtl/syl_fetch_seq.sv
module syl_fetch_seq
  import sylseq_pkg::*;
#(
  parameter int SYL_W = 12,
  parameter int SYL_N = 4,
  parameter int ADDR_W = 15,
  parameter int Q_W = 9,
  parameter int Q_HW_BIT = 6,
  parameter int Q_ADDER_BIT = 8,
  parameter logic [SYL_W-1:0] INT_SYL = 12'h609,
  localparam int IDX_W = $clog2(SYL_N),
  localparam int WORD_W = SYL_W * SYL_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              syl_done,
  input  logic              int_pending,
  input  logic              normal_state,
  input  logic              char_mode,
  input  logic [Q_W-1:0]    q_set,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SYL_W-1:0]  t_syl,
  output logic              t_valid,
  output logic [1:0]        syl_class,
  output logic [IDX_W-1:0]  syl_idx,
  output logic [Q_W-1:0]    q_flags,
  output logic              clr_serial,
  output logic              clr_cm
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYL_N - 1);

  function automatic logic [SYL_W-1:0] first_syl(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: SYL_W];
  endfunction

  function automatic logic [IDX_W-1:0] bump_idx(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + IDX_W'(1);
  endfunction

  logic [ADDR_W-1:0] c_q;
  logic [IDX_W-1:0]  l_q;
  logic [WORD_W-1:0] p_q;
  logic [SYL_W-1:0]  t_q;
  logic              tv_q;
  logic              fetching_q;
  logic              boot_q;

  // named events for assertions
  logic             syl_end;
  logic             inject;
  logic             advance;
  logic             at_last;
  logic             fetch_done;
  logic [SYL_W-1:0] next_syl;
  syl_class_e       cls;

  assign syl_end    = syl_done && tv_q;
  assign inject     = syl_end && int_pending && normal_state;
  assign advance    = syl_end && !inject;
  assign at_last    = (l_q == LAST_IDX);
  assign fetch_done = fetching_q && mem_ack;

  syl_select #(.SYL_W(SYL_W), .SYL_N(SYL_N)) u_sel (
    .word (p_q),
    .idx  (l_q),
    .syl  (next_syl)
  );

  syl_class_dec u_dec (
    .low_bits (t_q[1:0]),
    .cls      (cls)
  );

  q_flag_unit #(.Q_W(Q_W), .HW_BIT(Q_HW_BIT), .ADDER_BIT(Q_ADDER_BIT)) u_q (
    .clk     (clk),
    .rst_n   (rst_n),
    .syl_end (syl_end),
    .inject  (inject),
    .q_set   (q_set),
    .q_out   (q_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q        <= '0;
      l_q        <= '0;
      p_q        <= '0;
      t_q        <= '0;
      tv_q       <= 1'b0;
      fetching_q <= 1'b1;
      boot_q     <= 1'b1;
    end else if (fetch_done) begin
      p_q        <= mem_data;
      fetching_q <= 1'b0;
      tv_q       <= 1'b1;
      if (boot_q) begin
        t_q    <= first_syl(mem_data);
        l_q    <= IDX_W'(1);
        boot_q <= 1'b0;
      end
    end else if (inject) begin
      t_q <= INT_SYL;
    end else if (advance) begin
      t_q <= next_syl;
      l_q <= bump_idx(l_q);
      if (at_last) begin
        c_q        <= c_q + ADDR_W'(1);
        fetching_q <= 1'b1;
        tv_q       <= 1'b0;
      end
    end
  end

  assign mem_req    = fetching_q;
  assign mem_addr   = c_q;
  assign t_syl      = t_q;
  assign t_valid    = tv_q;
  assign syl_idx    = l_q;
  assign syl_class  = cls;
  assign clr_serial = syl_end;
  assign clr_cm     = syl_end && char_mode;

  assert_inject_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> ($stable(l_q) && $stable(c_q) && t_q == INT_SYL));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_last) |=> (l_q == $past(l_q) + IDX_W'(1)));

  assert_wrap_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && at_last) |=> (mem_req && l_q == '0 && c_q == $past(c_q) + ADDR_W'(1)));

  assert_no_valid_in_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !t_valid);

  assert_ack_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (t_valid && !mem_req && $stable(c_q)));

  assert_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (syl_done && !tv_q && !mem_ack) |=> ($stable(c_q) && $stable(l_q) && $stable(t_q)));
endmodule

// File: tb/tb_syl_fetch_seq.sv
module tb_syl_fetch_seq;
  localparam int NWORDS = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        syl_done = 1'b0;
  logic        int_pending = 1'b0;
  logic        normal_state = 1'b0;
  logic        char_mode = 1'b0;
  logic [8:0]  q_set = '0;
  logic        mem_ack = 1'b0;
  logic [47:0] mem_data = '0;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic [11:0] t_syl;
  logic        t_valid;
  logic [1:0]  syl_class;
  logic [1:0]  syl_idx;
  logic [8:0]  q_flags;
  logic        clr_serial;
  logic        clr_cm;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [47:0] exp_p;
  logic [11:0] exp_t;
  int          exp_l;
  int          exp_c;
  logic [8:0]  exp_q;

  always #2 clk = ~clk;

  syl_fetch_seq dut (
    .clk(clk), .rst_n(rst_n), .syl_done(syl_done), .int_pending(int_pending),
    .normal_state(normal_state), .char_mode(char_mode), .q_set(q_set),
    .mem_ack(mem_ack), .mem_data(mem_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .t_syl(t_syl), .t_valid(t_valid),
    .syl_class(syl_class), .syl_idx(syl_idx), .q_flags(q_flags),
    .clr_serial(clr_serial), .clr_cm(clr_cm)
  );

  function automatic logic [47:0] word_of(input int a);
    logic [15:0] hi, mid, lo;
    hi  = 16'(a * 40503 + 7);
    mid = 16'(a * 3 + 16'hC0DE);
    lo  = 16'(a) ^ 16'h1234 ^ 16'(a << 5);
    return {hi, mid, lo};
  endfunction

  function automatic logic [11:0] syl_of(input logic [47:0] w, input int k);
    return 12'((w >> (36 - 12 * k)) & 48'hFFF);
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, "t_syl", t_syl, exp_t);
    check(req, "syl_idx", syl_idx, exp_l);
    check(req, "mem_addr", mem_addr, exp_c);
    check("R10", "syl_class", syl_class, exp_t[1:0]);
  endtask

  task automatic serve(input int lat, input bit boot);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      syl_done = (i == 0);
      check("R4", "mem_req during fetch", mem_req, 1);
      check("R4", "t_valid during fetch", t_valid, 0);
    end
    @(negedge clk);
    syl_done = 1'b0;
    if (!boot) check_state("R11");
    mem_ack = 1'b1;
    mem_data = word_of(exp_c);
    @(negedge clk);
    mem_ack = 1'b0;
    exp_p = word_of(exp_c);
    if (boot) begin
      exp_t = syl_of(exp_p, 0);
      exp_l = 1;
      check_state("R2");
      check("R2", "t_valid", t_valid, 1);
    end else begin
      check_state("R5");
    end
    check("R5", "t_valid after ack", t_valid, 1);
    check("R5", "mem_req after ack", mem_req, 0);
  endtask

  task automatic syl_step(input int n);
    bit ip, ns, cm, inj;
    string req;
    ip = (n % 5 == 2);
    ns = (n % 3 != 0);
    cm = (n % 4 == 1);
    inj = ip && ns;
    if (n % 7 == 3) begin
      @(negedge clk);
      q_set = 9'h100 | 9'(n & 8'h3F);
      @(negedge clk);
      q_set = '0;
      exp_q = exp_q | 9'h100 | 9'(n & 8'h3F);
      check("R12", "q_flags accumulate", q_flags, exp_q);
    end
    @(negedge clk);
    syl_done = 1'b1;
    int_pending = ip;
    normal_state = ns;
    char_mode = cm;
    #1;
    check("R8", "clr_serial at end", clr_serial, 1);
    check("R9", "clr_cm at end", clr_cm, cm);
    @(negedge clk);
    syl_done = 1'b0;
    int_pending = 1'b0;
    normal_state = 1'b0;
    char_mode = 1'b0;
    #1;
    check("R8", "clr_serial idle", clr_serial, 0);
    check("R9", "clr_cm idle", clr_cm, 0);
    if (inj) begin
      exp_t = 12'h609;
      exp_q = 9'h040;
      req = "R6";
    end else begin
      exp_q = '0;
      exp_t = syl_of(exp_p, exp_l);
      req = ip ? "R7" : (exp_l == 3 ? "R4" : "R3");
      if (exp_l == 3) begin
        exp_l = 0;
        exp_c = exp_c + 1;
      end else begin
        exp_l = exp_l + 1;
      end
    end
    check_state(req);
    check(inj ? "R6" : "R8", "q_flags after end", q_flags, exp_q);
    if (!inj && exp_l == 0) begin
      check("R4", "mem_req after wrap", mem_req, 1);
      check("R4", "t_valid after wrap", t_valid, 0);
      serve(exp_c % 4, 1'b0);
    end else begin
      check(req, "t_valid", t_valid, 1);
    end
  endtask

  initial begin
    exp_c = 0;
    exp_l = 0;
    exp_t = '0;
    exp_q = '0;
    exp_p = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "mem_req", mem_req, 1);
    check("R1", "mem_addr", mem_addr, 0);
    check("R1", "t_valid", t_valid, 0);
    check("R1", "syl_idx", syl_idx, 0);
    check("R1", "q_flags", q_flags, 0);
    serve(2, 1'b1);
    for (int n = 0; n < 1000 && exp_c < NWORDS; n++) syl_step(n);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule